// File: doc/BRIEF.md
# DAC Channel Input Conditioner

This block prepares the 8-bit code for one converter channel. A shared cosine source supplies a signed sample together with a one-cycle valid strobe. The channel shrinks that sample by a power of two, adds its own DC level with modulo-256 wrap, and applies one of four bit-inversion patterns. Inversion is the last step. The MSB-only pattern turns the signed sample into an offset-binary code, which puts the two halves of the cosine back in their proper order.

A tone-select input chooses the source. When it is high, the conditioned cosine drives the channel. When it is low, a direct 8-bit value from software drives the channel without any conditioning. A two-channel system uses two instances that share the cosine sample and strobe.

A two-state source machine controls the output register.
- In `SRC_DIRECT`, the register loads the direct value on every clock.
- In `SRC_TONE`, the register loads the conditioned sample only on cycles where the strobe is high, and holds its value otherwise.
- Transition `DIRECT_TO_TONE` is taken on a clock where tone-select is high. The output keeps the last direct value until the first strobe arrives.
- Transition `TONE_TO_DIRECT` is taken on a clock where tone-select is low. The direct value is loaded on that same edge.

Top module: `dac_chan_cond`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `dac_code` is 0x00 and the source state is `SRC_DIRECT`.
- R2: When `tone_sel` is 0 at a clock edge, `dac_code` equals the `direct_code` sampled at that edge. `scale_sel`, `dc_offset`, `inv_mode`, `cos_sample` and `sample_valid` have no effect in this mode.
- R3: When `tone_sel` is 1 and `sample_valid` is 0 at a clock edge, `dac_code` keeps its value.
- R4: With `inv_mode` 2'b00, the tone result passes to `dac_code` unchanged.
- R5: With `inv_mode` 2'b01, all eight bits of the tone result are inverted.
- R6: With `inv_mode` 2'b10, only bit 7 of the tone result is inverted.
- R7: With `inv_mode` 2'b11, bits 6..0 of the tone result are inverted and bit 7 is kept.
- R8: `cos_sample` is read as two's complement. `scale_sel` values 0 to 3 shift it arithmetically right by 0 to 3 bits, which rounds toward minus infinity. For example, 0x80 with code 3 gives 0xF0.
- R9: `dc_offset` is added to the scaled sample modulo 256, and this happens before inversion.
- R10: After a switch from direct to tone, `dac_code` keeps the last direct value until the first edge where `sample_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_sel | input | 1 | 1 = conditioned cosine, 0 = direct value |
| sample_valid | input | 1 | Strobe that marks a new cosine sample |
| cos_sample | input | 8 | Shared cosine sample, two's complement |
| direct_code | input | 8 | Direct value from software |
| scale_sel | input | 2 | Right-shift amount applied to the sample |
| dc_offset | input | 8 | DC level added modulo 256 |
| inv_mode | input | 2 | Inversion pattern |
| dac_code | output | 8 | Registered converter code |

## Verification
The bench drives the most negative sample (0x80) at every scale code and checks that the shift rounds down. A logical shift would instead produce large positive codes. It sets offsets that make the sum wrap past 0xFF, and an order bug such as adding the offset after inversion shows up as a mirrored level. It sends direct-mode cycles with random conditioning settings and strobes, which exposes any leak of the tone path into the register path. It also switches source while the strobe is low, which catches an output that loads stale tone data or drops the held direct value.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_TONE   = 1'b1
    } src_state_t;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ALL  = 2'b01,
        INV_MSB  = 2'b10,
        INV_LOW  = 2'b11
    } inv_mode_t;
endpackage

// File: rtl/dacc_scale_offset.sv
module dacc_scale_offset #(
    parameter int DW      = 8,
    parameter int SCALE_W = 2
) (
    input  logic [DW-1:0]      sample,
    input  logic [SCALE_W-1:0] shift,
    input  logic [DW-1:0]      offset,
    output logic [DW-1:0]      level
);
    logic signed [DW-1:0] shifted;

    // signed view of the sample, floor-rounding shift
    assign shifted = $signed(sample) >>> shift;
    // modulo 2^DW addition
    assign level   = $unsigned(shifted) + offset;
endmodule

// File: rtl/dacc_invert.sv
module dacc_invert
    import dacc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    input  logic [1:0]    mode,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LOW_MASK = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] mask;

    always_comb begin
        unique case (inv_mode_t'(mode))
            INV_NONE: mask = '0;
            INV_ALL:  mask = '1;
            INV_MSB:  mask = MSB_MASK;
            INV_LOW:  mask = LOW_MASK;
            default:  mask = '0;
        endcase
    end

    assign dout = din ^ mask;
endmodule

// File: rtl/dac_chan_cond.sv
module dac_chan_cond
    import dacc_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tone_sel,
    input  logic               sample_valid,
    input  logic [DW-1:0]      cos_sample,
    input  logic [DW-1:0]      direct_code,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic [DW-1:0]      dc_offset,
    input  logic [1:0]         inv_mode,
    output logic [DW-1:0]      dac_code
);
    src_state_t    state, next_state;
    logic [DW-1:0] level;
    logic [DW-1:0] tone_code;

    dacc_scale_offset #(.DW(DW), .SCALE_W(SCALE_W)) i_scale (
        .sample (cos_sample),
        .shift  (scale_sel),
        .offset (dc_offset),
        .level  (level)
    );

    dacc_invert #(.DW(DW)) i_inv (
        .din  (level),
        .mode (inv_mode),
        .dout (tone_code)
    );

    // next-state: DIRECT_TO_TONE / TONE_TO_DIRECT follow tone_sel
    always_comb begin
        unique case (state)
            SRC_DIRECT: next_state = tone_sel ? SRC_TONE : SRC_DIRECT;
            SRC_TONE:   next_state = tone_sel ? SRC_TONE : SRC_DIRECT;
            default:    next_state = SRC_DIRECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_DIRECT;
        else        state <= next_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code <= '0;
        end else begin
            unique case (next_state)
                SRC_DIRECT: dac_code <= direct_code;
                SRC_TONE:   if (sample_valid) dac_code <= tone_code;
                default:    dac_code <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dac_chan_cond_chk.sv
module dac_chan_cond_chk
    import dacc_pkg::*;
#(
    parameter int DW      = 8,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tone_sel,
    input logic               sample_valid,
    input logic [DW-1:0]      cos_sample,
    input logic [DW-1:0]      direct_code,
    input logic [SCALE_W-1:0] scale_sel,
    input logic [DW-1:0]      dc_offset,
    input logic [1:0]         inv_mode,
    input logic [DW-1:0]      dac_code,
    input src_state_t         state
);
    localparam logic [DW-1:0] TOP_BIT = {1'b1, {(DW-1){1'b0}}};

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_state_chk: assert (state == SRC_DIRECT);
        end
    end

    // R2
    direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_sel |=> dac_code == $past(direct_code));

    // R3
    tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_sel && !sample_valid) |=> $stable(dac_code));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_sel && sample_valid && inv_mode == 2'b00 && scale_sel == '0 && dc_offset == '0)
        |=> dac_code == $past(cos_sample));

    // R5
    invert_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_sel && sample_valid && inv_mode == 2'b01 && scale_sel == '0 && dc_offset == '0)
        |=> dac_code == ~$past(cos_sample));

    // R6
    invert_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_sel && sample_valid && inv_mode == 2'b10 && scale_sel == '0 && dc_offset == '0)
        |=> dac_code == ($past(cos_sample) ^ TOP_BIT));

    // R10
    switch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_DIRECT && tone_sel && !sample_valid) |=> $stable(dac_code));
endmodule

bind dac_chan_cond dac_chan_cond_chk #(.DW(DW), .SCALE_W(SCALE_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tone_sel     (tone_sel),
    .sample_valid (sample_valid),
    .cos_sample   (cos_sample),
    .direct_code  (direct_code),
    .scale_sel    (scale_sel),
    .dc_offset    (dc_offset),
    .inv_mode     (inv_mode),
    .dac_code     (dac_code),
    .state        (state)
);

// File: tb/test_dac_chan_cond.sv
`timescale 1ns/1ps
module test_dac_chan_cond;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_sel = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] cos_sample = '0;
    logic [7:0] direct_code = '0;
    logic [1:0] scale_sel = '0;
    logic [7:0] dc_offset = '0;
    logic [1:0] inv_mode = '0;
    logic [7:0] dac_code;

    int    checks = 0;
    int    errors = 0;
    int    exp_code = 0;
    string tag = "R1";
    bit    last_direct = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_chan_cond i_dac_chan_cond (
        .clk          (clk),
        .rst_n        (rst_n),
        .tone_sel     (tone_sel),
        .sample_valid (sample_valid),
        .cos_sample   (cos_sample),
        .direct_code  (direct_code),
        .scale_sel    (scale_sel),
        .dc_offset    (dc_offset),
        .inv_mode     (inv_mode),
        .dac_code     (dac_code)
    );

    function automatic int ref_tone(int c, int sc, int off, int md);
        int v, d, m, q, x;
        v = (c >= 128) ? c - 256 : c;
        d = 1 << sc;
        m = ((v % d) + d) % d;
        q = (v - m) / d;
        x = (((q + off) % 256) + 256) % 256;
        case (md)
            1:       x = 255 - x;
            2:       x = (x + 128) % 256;
            3:       x = (x >= 128) ? 128 + (127 - (x - 128)) : 127 - x;
            default: x = x;
        endcase
        return x;
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_code    <= 0;
            tag         <= "R1";
            last_direct <= 1'b1;
        end else if (!tone_sel) begin
            exp_code    <= direct_code;
            tag         <= "R2";
            last_direct <= 1'b1;
        end else begin
            last_direct <= 1'b0;
            if (sample_valid) begin
                exp_code <= ref_tone(cos_sample, scale_sel, dc_offset, inv_mode);
                if (dc_offset != 0)      tag <= "R9";
                else if (scale_sel != 0) tag <= "R8";
                else case (inv_mode)
                    2'd0: tag <= "R4";
                    2'd1: tag <= "R5";
                    2'd2: tag <= "R6";
                    default: tag <= "R7";
                endcase
            end else begin
                tag <= last_direct ? "R10" : "R3";
            end
        end
    end

    task automatic compare(string req, int expv);
        checks++;
        if (dac_code !== expv[7:0]) begin
            errors++;
            $display("FAIL %s: dac_code=0x%02h expected=0x%02h", req, dac_code, expv[7:0]);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare(tag, exp_code);
    endtask

    task automatic set_tone(int c, int sc, int off, int md);
        tone_sel = 1'b1; sample_valid = 1'b1;
        cos_sample = c[7:0]; scale_sel = sc[1:0];
        dc_offset = off[7:0]; inv_mode = md[1:0];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1", 0);
        rst_n = 1'b1;
        tick();                         // R1: direct mode, direct_code 0

        // R2: direct value passes, conditioning settings ignored
        direct_code = 8'h5A; scale_sel = 2'd3; dc_offset = 8'h44;
        inv_mode = 2'd1; sample_valid = 1'b1; cos_sample = 8'hC3;
        tick();
        compare("R2", 8'h5A);

        // R10: switch to tone with no strobe holds 0x5A
        tone_sel = 1'b1; sample_valid = 1'b0; direct_code = 8'h11;
        tick();
        compare("R10", 8'h5A);

        // R8 + R9 + R7: 0x80 >>>3 = 0xF0, +0x10 = 0x00, inv low -> 0x7F
        set_tone(8'h80, 3, 8'h10, 3);
        tick();
        compare("R9", 8'h7F);

        // R8 + R6: 0x7F >>>1 = 0x3F, MSB flip -> 0xBF
        set_tone(8'h7F, 1, 0, 2);
        tick();
        compare("R8", 8'hBF);

        // R8 + R5: 0xFF >>>2 stays 0xFF, invert all -> 0x00
        set_tone(8'hFF, 2, 0, 1);
        tick();
        compare("R8", 8'h00);

        // R4: pass through
        set_tone(8'h9C, 0, 0, 0);
        tick();
        compare("R4", 8'h9C);

        // R3: strobe low holds
        sample_valid = 1'b0; cos_sample = 8'h01;
        tick();
        compare("R3", 8'h9C);

        // R9: wrap 0x7F + 0x90 = 0x0F
        set_tone(8'h7F, 0, 8'h90, 0);
        tick();
        compare("R9", 8'h0F);

        // R8: most negative sample at each scale
        for (int s = 0; s < 4; s++) begin
            set_tone(8'h80, s, 0, 0);
            tick();
            compare("R8", 256 - (128 >> s));
        end

        // random mixed traffic, compared every clock
        for (int i = 0; i < 3000; i++) begin
            tone_sel     = ($urandom_range(0, 9) != 0) ? tone_sel : ~tone_sel;
            sample_valid = $urandom_range(0, 3) == 0;
            cos_sample   = 8'($urandom);
            direct_code  = 8'($urandom);
            scale_sel    = 2'($urandom);
            dc_offset    = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
            inv_mode     = 2'($urandom);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule